// File: doc/BRIEF.md
# Platform-Level Interrupt Arbiter

This block collects a parameterised set of external interrupt lines and routes them to several targets. A target is one privilege level of one hardware thread. Every source holds a pending flag, a programmable priority and a trigger type, which is either level or rising edge. Every target holds a mask of enabled sources and a priority threshold. The block drives one request line per target.

A target services an interrupt in two steps. It reads its claim register, which returns the best eligible source and marks that source as in service. When the handler finishes, the target writes the same source number back to that register to complete it. Edge sources can count the edges that arrive while they are pending or in service, and replay one interrupt per completion. This replay is chosen at elaboration time, so software needs no trigger-specific handling.

One access port, with a supervisor flag, reaches all registers. A delegation bit opens the configuration registers to supervisor-level accesses.

Top module: `intc_core`

## Requirements
- R1: After reset all priorities, trigger types, enables, thresholds, counters, pending and in-service flags and the delegation bit are zero, every request line is low, and a claim read returns 0.
- R2: A claim read of a target returns the number of its best eligible source, clears that source's pending flag and marks it in service for that target. A source is eligible for a target when it is pending, enabled for that target and has a nonzero priority. With nothing eligible, the read returns 0. Source 0 has no line and is never eligible.
- R3: Among the eligible sources of a target, the highest priority wins. Equal priorities go to the lowest source number. Priority 0 keeps a source from ever interrupting.
- R4: Bit s of a target's enable word lets source s reach that target and no other target.
- R5: The request line of target t is high exactly when its best eligible source has a priority greater than or equal to the threshold of t. A claim read ignores the threshold.
- R6: Writing a source number to a target's claim register completes that source only if that target currently has it in service. Any other completion write has no effect.
- R7: A level source that is not in service copies its input line into its pending flag. After completion the flag is taken again from the line, so a line still high raises the request again and a low line leaves the flag clear.
- R8: A source in service is never pending until it is completed.
- R9: An edge source (trigger bit 1) becomes pending on a rising edge of its line. A line that stays high does not make it pending again after completion.
- R10: With QUEUE_EDGES=1, every rising edge on an edge source that arrives while the source is pending or in service adds one to a counter that saturates at 2^CW-1. Each completion then takes one off the counter and makes the source pending again while the counter was nonzero.
- R11: With QUEUE_EDGES=0, edges that arrive while an edge source is pending or in service are discarded. After completion the source is not pending.
- R12: While the delegation bit is 0, a supervisor access (acc_sup=1) to the priority, trigger, enable or threshold registers is ignored: a write changes nothing and a read returns 0. The delegation bit itself ignores writes from supervisor accesses.
- R13: Address map (8-bit address):
  - priority of source s: s
  - trigger of source s: 0x40+s
  - enable word of target t: 0x80+4t
  - threshold of target t: 0x81+4t
  - claim/complete of target t: 0x82+4t
  - delegation bit: 0xC0
  - pending vector, bit s for source s, read-only: 0xC1

  Read data appears on acc_rdata one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | NSRC-1 | Interrupt lines of sources 1..NSRC-1 |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_sup | input | 1 | Access issued at supervisor level |
| acc_addr | input | AW | Register address |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Registered read data |
| irq | output | NTGT | Request line per target |

## Verification
Arbitration is tried with many priority patterns computed arithmetically. In each pattern every source is held pending and claimed repeatedly until a claim returns 0, so the sequence of returned numbers shows priority order, tie breaking and the exclusion of priority 0 together. A full sweep of priority against threshold separates the greater-or-equal gate from a strict comparison. Edge replay is swept over zero to five edges arriving during service, on a queueing instance and a dropping instance that take the same stimulus, which shows saturation and the difference between the two modes. Separate patterns cover per-target enables, completions written by the wrong target, level lines dropping before completion, and supervisor accesses with and without delegation.

// File: rtl/intc_core.sv
module intc_core #(
  parameter int NSRC = 8,
  parameter int NTGT = 2,
  parameter int PW = 3,
  parameter int CW = 2,
  parameter int QUEUE_EDGES = 1,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:1]   src_line,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_sup,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  output logic [NTGT-1:0]   irq
);
  localparam int IW = $clog2(NSRC);
  localparam int TW = NTGT > 1 ? $clog2(NTGT) : 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [AW-3:0] SRC_LIM = (AW-2)'(NSRC);
  localparam logic [AW-5:0] TGT_LIM = (AW-4)'(NTGT);

  logic [NSRC-1:0][PW-1:0] prio;
  logic [NSRC-1:0]         edge_mode, pend, active;
  logic [NSRC-1:1]         line_q;
  logic [NSRC-1:1][CW-1:0] cnt;
  logic [NSRC-1:1][TW-1:0] owner;
  logic [NTGT-1:0][NSRC-1:0] en;
  logic [NTGT-1:0][PW-1:0] thr;
  logic                    deleg;
  logic [NTGT-1:0][IW-1:0] best_id;
  logic [NTGT-1:0][PW-1:0] best_pr;
  logic [DW-1:0]           rd_val;

  wire [1:0]    region = acc_addr[AW-1:AW-2];
  wire [AW-3:0] a_lo   = acc_addr[AW-3:0];
  wire [AW-5:0] a_tsel = acc_addr[AW-3:2];
  wire [1:0]    a_k    = acc_addr[1:0];
  wire [IW-1:0] a_src  = IW'(a_lo);
  wire [TW-1:0] a_tgt  = TW'(a_tsel);
  wire src_ok  = a_lo < SRC_LIM;
  wire tgt_ok  = a_tsel < TGT_LIM;
  wire cfg_hit = (region == 2'd0) || (region == 2'd1) || (region == 2'd2 && !a_k[1]);
  wire blocked = acc_sup && !deleg && cfg_hit;
  wire do_wr   = acc_valid && acc_write && !blocked;
  wire do_rd   = acc_valid && !acc_write;
  wire clm_reg = region == 2'd2 && tgt_ok && a_k == 2'd2;
  wire claim   = do_rd && clm_reg;
  wire [IW-1:0] claim_id = best_id[a_tgt];
  wire [IW-1:0] cmp_id   = acc_wdata[IW-1:0];
  wire cmp_ok  = do_wr && clm_reg && (acc_wdata < DW'(NSRC)) && cmp_id != '0 &&
                 active[cmp_id] && owner[cmp_id] == a_tgt;

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      best_id[t] = '0;
      best_pr[t] = '0;
      for (int s = NSRC - 1; s >= 1; s--)
        if (pend[s] && en[t][s] && prio[s] != '0 && prio[s] >= best_pr[t]) begin
          best_id[t] = IW'(s);
          best_pr[t] = prio[s];
        end
    end
  end

  for (genvar t = 0; t < NTGT; t++) begin : g_irq
    assign irq[t] = (best_id[t] != '0) && (best_pr[t] >= thr[t]);
  end

  always_comb begin
    rd_val = '0;
    if (!blocked)
      case (region)
        2'd0: if (src_ok) rd_val = DW'(prio[a_src]);
        2'd1: if (src_ok) rd_val = DW'(edge_mode[a_src]);
        2'd2: if (tgt_ok)
          case (a_k)
            2'd0: rd_val = DW'(en[a_tgt]);
            2'd1: rd_val = DW'(thr[a_tgt]);
            2'd2: rd_val = DW'(claim_id);
            default: rd_val = '0;
          endcase
        default: begin
          if (a_lo == '0) rd_val = DW'(deleg);
          else if (a_lo == (AW-2)'(1)) rd_val = DW'(pend);
        end
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio <= '0; edge_mode <= '0; en <= '0; thr <= '0; deleg <= 1'b0;
      acc_rdata <= '0;
    end else begin
      if (do_rd) acc_rdata <= rd_val;
      if (do_wr) begin
        if (region == 2'd0 && src_ok && a_lo != '0) prio[a_src] <= acc_wdata[PW-1:0];
        if (region == 2'd1 && src_ok && a_lo != '0) edge_mode[a_src] <= acc_wdata[0];
        if (region == 2'd2 && tgt_ok && a_k == 2'd0) en[a_tgt] <= acc_wdata[NSRC-1:0] & ~NSRC'(1);
        if (region == 2'd2 && tgt_ok && a_k == 2'd1) thr[a_tgt] <= acc_wdata[PW-1:0];
        if (region == 2'd3 && a_lo == '0 && !acc_sup) deleg <= acc_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; active <= '0; line_q <= '0; cnt <= '0; owner <= '0;
    end else begin
      line_q <= src_line;
      for (int s = 1; s < NSRC; s++) begin
        if (claim && claim_id == IW'(s)) begin
          pend[s]   <= 1'b0;
          active[s] <= 1'b1;
          owner[s]  <= a_tgt;
          if (QUEUE_EDGES != 0 && edge_mode[s] && src_line[s] && !line_q[s] && cnt[s] != CMAX)
            cnt[s] <= cnt[s] + CW'(1);
        end else if (cmp_ok && cmp_id == IW'(s)) begin
          active[s] <= 1'b0;
          if (edge_mode[s] && QUEUE_EDGES != 0 && cnt[s] != '0) begin
            cnt[s]  <= cnt[s] - CW'(1);
            pend[s] <= 1'b1;
          end else begin
            pend[s] <= 1'b0;
          end
        end else if (edge_mode[s]) begin
          if (src_line[s] && !line_q[s]) begin
            if (pend[s] || active[s]) begin
              if (QUEUE_EDGES != 0 && cnt[s] != CMAX) cnt[s] <= cnt[s] + CW'(1);
            end else begin
              pend[s] <= 1'b1;
            end
          end
        end else if (!active[s]) begin
          pend[s] <= src_line[s];
        end
      end
    end
  end

  for (genvar s = 1; s < NSRC; s++) begin : g_src_chk
    a_r8_claimed_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
      active[s] |-> !pend[s]);
  end

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt_chk
    a_r4_irq_needs_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq[t] |-> |(pend & en[t]));
  end

  a_r2_claim_takes_service: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && claim_id != '0) |=> active[$past(claim_id)] && !pend[$past(claim_id)]);

  a_r6_foreign_complete_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && clm_reg && !cmp_ok) |=> $stable(active));

  a_r12_sup_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sup && !deleg) |=>
      $stable(prio) && $stable(edge_mode) && $stable(en) && $stable(thr) && $stable(deleg));
endmodule

// File: tb/tb_intc_core.sv
`timescale 1ns/1ps
module tb_intc_core;
  localparam int NSRC = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:1] src_line = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_sup = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rdata, rdata_d;
  logic [1:0] irq, irq_d;
  int n_chk = 0, n_fail = 0;
  logic [31:0] q, qd;

  always #2 clk = ~clk;

  intc_core #(.QUEUE_EDGES(1)) dut (.clk, .rst_n, .src_line, .acc_valid, .acc_write,
    .acc_sup, .acc_addr, .acc_wdata, .acc_rdata(rdata), .irq(irq));
  intc_core #(.QUEUE_EDGES(0)) dut_drop (.clk, .rst_n, .src_line, .acc_valid, .acc_write,
    .acc_sup, .acc_addr, .acc_wdata, .acc_rdata(rdata_d), .irq(irq_d));

  function automatic logic [7:0] a_prio(int s); return 8'(s); endfunction
  function automatic logic [7:0] a_trig(int s); return 8'(8'h40 + s); endfunction
  function automatic logic [7:0] a_en(int t);   return 8'(8'h80 + 4*t); endfunction
  function automatic logic [7:0] a_thr(int t);  return 8'(8'h81 + 4*t); endfunction
  function automatic logic [7:0] a_clm(int t);  return 8'(8'h82 + 4*t); endfunction
  localparam logic [7:0] A_DELEG = 8'hC0, A_PEND = 8'hC1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic sup = 1'b0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_sup = sup; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_sup = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic [31:0] dd, input logic sup = 1'b0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_sup = sup; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0; acc_sup = 1'b0;
    d = rdata; dd = rdata_d;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse(int s);
    @(negedge clk); src_line[s] = 1'b1;
    idle(2); src_line[s] = 1'b0; idle(1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(a_clm(0), q, qd); check("R1 claim", q, 0);
    rd(a_prio(3), q, qd); check("R1 prio", q, 0);
    rd(A_PEND, q, qd); check("R1 pend", q, 0);

    // R12 delegation
    wr(a_prio(2), 5, 1'b1);
    rd(a_prio(2), q, qd); check("R12 sup write blocked", q, 0);
    wr(A_DELEG, 1, 1'b1);
    rd(A_DELEG, q, qd); check("R12 sup deleg write ignored", q, 0);
    wr(A_DELEG, 1);
    wr(a_prio(2), 5, 1'b1);
    rd(a_prio(2), q, qd, 1'b1); check("R12 sup access delegated", q, 5);
    wr(A_DELEG, 0);
    rd(a_prio(2), q, qd, 1'b1); check("R12 sup read blocked", q, 0);
    rd(a_prio(2), q, qd); check("R12 machine read", q, 5);
    wr(a_prio(2), 0);

    // R2 R3 priority order sweep, level sources all high
    wr(a_en(0), 32'hFE);
    src_line = '1;
    for (int pat = 0; pat < 24; pat++) begin
      int pr[8];
      bit taken[8];
      bit any;
      any = 0;
      for (int s = 1; s < 8; s++) begin
        pr[s] = (pat * 5 + s * s * 3 + pat * s) % 8;
        taken[s] = 0;
        if (pr[s] != 0) any = 1;
        wr(a_prio(s), 32'(pr[s]));
      end
      idle(2);
      check("R5 irq thr0", 32'(irq[0]), 32'(any));
      for (int k = 0; k < 8; k++) begin
        int best, bp;
        best = 0; bp = 0;
        for (int s = 1; s < 8; s++)
          if (!taken[s] && pr[s] != 0 && pr[s] > bp) begin best = s; bp = pr[s]; end
        rd(a_clm(0), q, qd);
        check("R3 claim order", q, 32'(best));
        if (best != 0) taken[best] = 1;
      end
      for (int s = 1; s < 8; s++) if (taken[s]) wr(a_clm(0), 32'(s));
    end
    src_line = '0; idle(3);
    rd(A_PEND, q, qd); check("R7 level follows line", q, 0);

    // R5 threshold sweep on source 3
    for (int s = 1; s < 8; s++) wr(a_prio(s), 0);
    src_line[3] = 1'b1;
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 8; t++) begin
        wr(a_prio(3), 32'(p)); wr(a_thr(0), 32'(t)); idle(1);
        check("R5 threshold", 32'(irq[0]), 32'(p != 0 && p >= t));
      end
    wr(a_prio(3), 2); wr(a_thr(0), 5); idle(1);
    rd(a_clm(0), q, qd); check("R5 claim ignores threshold", q, 3);
    wr(a_clm(0), 3); wr(a_thr(0), 0);

    // R4 enables, R6 completion ownership, R7 re-sampling
    wr(a_prio(3), 4); wr(a_en(0), 0); wr(a_en(1), 32'h08); idle(2);
    check("R4 enable routing", 32'(irq), 2);
    rd(a_clm(0), q, qd); check("R4 unrouted claim", q, 0);
    rd(a_clm(1), q, qd); check("R2 claim target 1", q, 3);
    wr(a_clm(0), 3); idle(3);
    check("R6 foreign completion irq", 32'(irq), 0);
    rd(A_PEND, q, qd); check("R8 claimed not pending", q, 0);
    wr(a_clm(1), 3); idle(3);
    check("R7 re-sample high", 32'(irq), 2);
    rd(a_clm(1), q, qd); check("R2 reclaim", q, 3);
    src_line[3] = 1'b0; idle(1);
    wr(a_clm(1), 3); idle(3);
    rd(A_PEND, q, qd); check("R7 re-sample low", q, 0);
    check("R7 irq low", 32'(irq), 0);

    // R9 R10 R11 edge sources
    wr(a_en(1), 0); wr(a_prio(3), 0);
    wr(a_trig(5), 1); wr(a_prio(5), 3); wr(a_en(0), 32'h20);
    rd(a_trig(5), q, qd); check("R13 trigger readback", q, 1);
    for (int n = 0; n < 6; n++) begin
      int rep;
      rep = (n < 3) ? n : 3;
      pulse(5);
      rd(A_PEND, q, qd);
      check("R9 edge sets pending", q, 32'h20);
      check("R11 edge sets pending", qd, 32'h20);
      rd(a_clm(0), q, qd);
      check("R9 claim edge", q, 5);
      check("R11 claim edge", qd, 5);
      for (int e = 0; e < n; e++) pulse(5);
      for (int r = 0; r <= rep; r++) begin
        wr(a_clm(0), 5);
        rd(a_clm(0), q, qd);
        check("R10 replay", q, (r < rep) ? 32'd5 : 32'd0);
        check("R11 no replay", qd, 0);
      end
    end
    // R9 held line does not re-pend
    @(negedge clk); src_line[5] = 1'b1; idle(3);
    rd(a_clm(0), q, qd); check("R9 held claim", q, 5);
    wr(a_clm(0), 5); idle(3);
    rd(a_clm(0), q, qd); check("R9 held no repend", q, 0);
    src_line[5] = 1'b0; idle(2);
    check("R9 irq idle", 32'(irq), 0);
    finish_run();
  end
endmodule